// File: doc/BRIEF.md
# Exception Arbiter with Three Priority Groups

This block gathers every condition that can start exception processing and, once per clock, picks the one that wins. Some conditions come from the processor core: a misaligned access, a decoded opcode flagged as illegal or privileged, and the strobes from trap, overflow-trap, bound-check and divide-by-zero instructions. Others come from pins: a reset request, bus error qualified by halt, and a pending interrupt. The result is a registered one-hot selection, the vector number that stacking and vector-fetch logic elsewhere will use, and a flag saying whether the current instruction must be abandoned at once.

The conditions fall into three ranks. The top rank (reset, bus error, address error) is accepted in any cycle and aborts the running instruction. When it is accepted, every lower request still waiting is thrown away. The middle rank (trace, interrupt, illegal opcode, privilege violation) is taken only on the cycle that marks an instruction boundary. The bottom rank (divide by zero, bound check, overflow trap, software trap) is raised by the instruction itself and is served in any cycle that no higher rank claims. Decode faults and bottom-rank strobes are remembered until they are served or dropped.

Top module: `exc_arbiter`

## Requirements
- R1: While `rst_n` is low, `exc_valid`, `exc_sel`, `exc_vec` and `abort_now` are all zero, and every remembered request is cleared.
- R2: Outputs are registered. A request present at one rising edge shows on the outputs after that edge. `exc_sel` has at most one bit set: bit 0 reset, 1 bus error, 2 address error, 3 trace, 4 interrupt, 5 illegal, 6 privilege, 7 divide by zero, 8 bound check, 9 overflow trap, 10 software trap. `exc_valid` is 1 exactly when a bit is set.
- R3: An address error is raised when `acc_valid` is 1 and `addr_lsb` is 1, provided either `acc_fetch` is 1 or `acc_size` is not 00. Size code 00 means byte, 01 word and 10 long. A byte data access never raises it.
- R4: A bus error is raised only when `berr_n` is 0 and `halt_n` is 1 in the same cycle.
- R5: The top rank is taken in any cycle, ranked reset over bus error over address error. `abort_now` is 1 exactly when a top-rank exception is selected.
- R6: The middle rank is taken only in a cycle with `insn_done` high, ranked trace (`trace_en`) over interrupt (`irq_pend`) over illegal over privilege. Taking any middle-rank exception discards the remembered illegal and privilege flags.
- R7: A privilege violation is recorded only if `op_priv` is 1 while `sup_mode` is 0 in a cycle with `op_valid` high.
- R8: Illegal and privilege flags recorded with `op_valid` stay pending across cycles without `insn_done` and are served at the next instruction boundary.
- R9: The bottom rank is taken in any cycle, ranked divide by zero over bound check over overflow trap over software trap. Requests not served stay pending and are served one per cycle in that order.
- R10: Vector numbers: reset 0, bus error 2, address error 3, illegal 4, divide by zero 5, bound check 6, overflow trap 7, privilege 8, trace 9, interrupt 24 (the base that the acknowledge cycle refines), and software trap 32 plus `trap_num`.
- R11: Accepting a top-rank exception drops every pending lower-rank request, including strobes that arrive in that same cycle.
- R12: At an instruction boundary a middle-rank exception wins over bottom-rank requests, and those requests stay pending for later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| reset_req | input | 1 | External reset request |
| berr_n | input | 1 | Bus error, active low |
| halt_n | input | 1 | Halt, active low; qualifies bus error |
| acc_valid | input | 1 | A memory access is in progress |
| acc_size | input | 2 | Access size: 00 byte, 01 word, 10 long |
| acc_fetch | input | 1 | Access is an instruction fetch |
| addr_lsb | input | 1 | Bit 0 of the access address |
| op_valid | input | 1 | Decode flags below are valid this cycle |
| op_illegal | input | 1 | Opcode is illegal or unimplemented |
| op_priv | input | 1 | Opcode needs supervisor mode |
| sup_mode | input | 1 | Core is in supervisor mode |
| trace_en | input | 1 | Trace bit of the status word |
| insn_done | input | 1 | Instruction boundary strobe |
| irq_pend | input | 1 | An interrupt above the mask is pending |
| trap_stb | input | 1 | Software trap instruction executed |
| trap_num | input | 4 | Software trap number |
| trapv_stb | input | 1 | Overflow trap condition |
| chk_stb | input | 1 | Bound check failed |
| div0_stb | input | 1 | Division by zero |
| exc_valid | output | 1 | An exception is selected |
| exc_sel | output | 11 | One-hot selected exception |
| exc_vec | output | 8 | Vector number of the selection |
| abort_now | output | 1 | Abort the current instruction immediately |

## Verification
Every result appears one rising edge after the inputs that cause it. So the bench drives a cycle's inputs just after an edge, waits for the next edge plus a small delay, and then compares all four outputs with the expected winner. Behaviour that is remembered is checked over follow-up cycles. These are the decode faults waiting for a boundary, bottom-rank requests draining in rank order, and requests dropped by a top-rank exception. In those idle cycles the next expected winner is read at the same one-edge offset, and after the last one the outputs must show no exception.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int N_EXC   = 11;
    localparam int TRAP_W  = 4;
    localparam int VEC_W   = 8;
    localparam int PEND_LO = 5;
    localparam int N_PEND  = N_EXC - PEND_LO;

    localparam int EX_RESET = 0;
    localparam int EX_BERR  = 1;
    localparam int EX_AERR  = 2;
    localparam int EX_TRACE = 3;
    localparam int EX_IRQ   = 4;
    localparam int EX_ILL   = 5;
    localparam int EX_PRIV  = 6;
    localparam int EX_DIV0  = 7;
    localparam int EX_CHK   = 8;
    localparam int EX_TRAPV = 9;
    localparam int EX_TRAP  = 10;

    localparam int TOP_HI = EX_AERR;
    localparam int MID_LO = EX_TRACE;
    localparam int MID_HI = EX_PRIV;

    typedef struct packed {
        logic                valid;
        logic [N_EXC-1:0]    sel;
        logic [VEC_W-1:0]    vec;
        logic                abort;
        logic [N_PEND-1:0]   pend;
        logic [TRAP_W-1:0]   tnum;
    } arb_state_t;

    function automatic int vec_base(input int idx);
        case (idx)
            EX_RESET: return 0;
            EX_BERR:  return 2;
            EX_AERR:  return 3;
            EX_TRACE: return 9;
            EX_IRQ:   return 24;
            EX_ILL:   return 4;
            EX_PRIV:  return 8;
            EX_DIV0:  return 5;
            EX_CHK:   return 6;
            EX_TRAPV: return 7;
            EX_TRAP:  return 32;
            default:  return 0;
        endcase
    endfunction
endpackage

// File: rtl/exc_detect.sv
module exc_detect (
    input  logic       berr_n,
    input  logic       halt_n,
    input  logic       acc_valid,
    input  logic [1:0] acc_size,
    input  logic       acc_fetch,
    input  logic       addr_lsb,
    input  logic       op_valid,
    input  logic       op_illegal,
    input  logic       op_priv,
    input  logic       sup_mode,
    output logic       berr_hit,
    output logic       aerr_hit,
    output logic       ill_new,
    output logic       priv_new
);
    logic wide_acc;

    always_comb begin
        wide_acc = acc_fetch | (acc_size != 2'b00);
        berr_hit = ~berr_n & halt_n;
        aerr_hit = acc_valid & addr_lsb & wide_acc;
        ill_new  = op_valid & op_illegal;
        priv_new = op_valid & op_priv & ~sup_mode;
    end
endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
    parameter int W = 11
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] gnt
);
    logic [W:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_rank
        assign gnt[i]    = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
endmodule

// File: rtl/exc_vecgen.sv
module exc_vecgen
    import exc_pkg::*;
(
    input  logic [N_EXC-1:0]  gnt,
    input  logic [TRAP_W-1:0] tnum,
    output logic [VEC_W-1:0]  vec
);
    always_comb begin
        vec = '0;
        for (int i = 0; i < N_EXC; i++) begin
            if (gnt[i]) begin
                vec = VEC_W'(vec_base(i));
            end
        end
        if (gnt[EX_TRAP]) begin
            vec = VEC_W'(vec_base(EX_TRAP) + int'(tnum));
        end
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              berr_n,
    input  logic              halt_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_size,
    input  logic              acc_fetch,
    input  logic              addr_lsb,
    input  logic              op_valid,
    input  logic              op_illegal,
    input  logic              op_priv,
    input  logic              sup_mode,
    input  logic              trace_en,
    input  logic              insn_done,
    input  logic              irq_pend,
    input  logic              trap_stb,
    input  logic [TRAP_W-1:0] trap_num,
    input  logic              trapv_stb,
    input  logic              chk_stb,
    input  logic              div0_stb,
    output logic              exc_valid,
    output logic [N_EXC-1:0]  exc_sel,
    output logic [VEC_W-1:0]  exc_vec,
    output logic              abort_now
);
    arb_state_t st_q, st_d;

    logic berr_hit, aerr_hit, ill_new, priv_new;
    logic [N_PEND-1:0] new_pend, all_pend;
    logic [N_EXC-1:0]  req, gnt;
    logic [TRAP_W-1:0] tnum_eff;
    logic [VEC_W-1:0]  vec_w;

    exc_detect u_detect (
        .berr_n     (berr_n),
        .halt_n     (halt_n),
        .acc_valid  (acc_valid),
        .acc_size   (acc_size),
        .acc_fetch  (acc_fetch),
        .addr_lsb   (addr_lsb),
        .op_valid   (op_valid),
        .op_illegal (op_illegal),
        .op_priv    (op_priv),
        .sup_mode   (sup_mode),
        .berr_hit   (berr_hit),
        .aerr_hit   (aerr_hit),
        .ill_new    (ill_new),
        .priv_new   (priv_new)
    );

    exc_pick #(.W(N_EXC)) u_pick (
        .req (req),
        .gnt (gnt)
    );

    exc_vecgen u_vecgen (
        .gnt  (gnt),
        .tnum (tnum_eff),
        .vec  (vec_w)
    );

    always_comb begin
        new_pend = {trap_stb, trapv_stb, chk_stb, div0_stb, priv_new, ill_new};
        all_pend = st_q.pend | new_pend;
        tnum_eff = trap_stb ? trap_num : st_q.tnum;

        req                    = '0;
        req[EX_RESET]          = reset_req;
        req[EX_BERR]           = berr_hit;
        req[EX_AERR]           = aerr_hit;
        req[EX_TRACE]          = insn_done & trace_en;
        req[EX_IRQ]            = insn_done & irq_pend;
        req[EX_ILL]            = insn_done & all_pend[EX_ILL - PEND_LO];
        req[EX_PRIV]           = insn_done & all_pend[EX_PRIV - PEND_LO];
        req[N_EXC-1:EX_DIV0]   = all_pend[N_PEND-1:EX_DIV0 - PEND_LO];

        st_d       = st_q;
        st_d.valid = |req;
        st_d.sel   = gnt;
        st_d.vec   = vec_w;
        st_d.abort = |gnt[TOP_HI:0];
        st_d.tnum  = tnum_eff;

        if (st_d.abort) begin
            st_d.pend = '0;
        end else begin
            st_d.pend = all_pend & ~gnt[N_EXC-1:PEND_LO];
            if (|gnt[MID_HI:MID_LO]) begin
                st_d.pend[EX_ILL - PEND_LO]  = 1'b0;
                st_d.pend[EX_PRIV - PEND_LO] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_valid = st_q.valid;
    assign exc_sel   = st_q.sel;
    assign exc_vec   = st_q.vec;
    assign abort_now = st_q.abort;
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk
    import exc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reset_req,
    input logic             berr_n,
    input logic             halt_n,
    input logic             insn_done,
    input logic             exc_valid,
    input logic [N_EXC-1:0] exc_sel,
    input logic [VEC_W-1:0] exc_vec,
    input logic             abort_now
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exc_sel) && (exc_valid == (exc_sel != '0))); // R2

    AST_ABORT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        abort_now == (exc_sel[TOP_HI:0] != '0)); // R5

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> exc_sel[EX_RESET]); // R5

    AST_BERR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!berr_n && halt_n && !reset_req) |=> exc_sel[EX_BERR]); // R4

    AST_MID_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_done |=> (exc_sel[MID_HI:MID_LO] == '0)); // R6

    AST_TRAP_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        exc_sel[EX_TRAP] |-> (exc_vec >= VEC_W'(32))); // R10
endmodule

bind exc_arbiter exc_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_req (reset_req),
    .berr_n    (berr_n),
    .halt_n    (halt_n),
    .insn_done (insn_done),
    .exc_valid (exc_valid),
    .exc_sel   (exc_sel),
    .exc_vec   (exc_vec),
    .abort_now (abort_now)
);

// File: tb/exc_arbiter_bench.sv
module exc_arbiter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_req = 0, berr_n = 1, halt_n = 1, acc_valid = 0;
    logic [1:0] acc_size = 0;
    logic acc_fetch = 0, addr_lsb = 0, op_valid = 0, op_illegal = 0, op_priv = 0;
    logic sup_mode = 0, trace_en = 0, insn_done = 0, irq_pend = 0;
    logic trap_stb = 0, trapv_stb = 0, chk_stb = 0, div0_stb = 0;
    logic [3:0] trap_num = 0;
    logic exc_valid, abort_now;
    logic [10:0] exc_sel;
    logic [7:0] exc_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    exc_arbiter u_exc_arbiter (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .berr_n(berr_n),
        .halt_n(halt_n), .acc_valid(acc_valid), .acc_size(acc_size),
        .acc_fetch(acc_fetch), .addr_lsb(addr_lsb), .op_valid(op_valid),
        .op_illegal(op_illegal), .op_priv(op_priv), .sup_mode(sup_mode),
        .trace_en(trace_en), .insn_done(insn_done), .irq_pend(irq_pend),
        .trap_stb(trap_stb), .trap_num(trap_num), .trapv_stb(trapv_stb),
        .chk_stb(chk_stb), .div0_stb(div0_stb), .exc_valid(exc_valid),
        .exc_sel(exc_sel), .exc_vec(exc_vec), .abort_now(abort_now)
    );

    function automatic int exp_vec(input int idx, input int tn);
        case (idx)
            0: return 0;   1: return 2;   2: return 3;   3: return 9;
            4: return 24;  5: return 4;   6: return 8;   7: return 5;
            8: return 6;   9: return 7;   10: return 32 + tn;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input int idx, input int tn, input string tag);
        logic [10:0] es;
        logic [7:0]  ev;
        logic        evld, eab;
        es   = (idx < 0) ? 11'd0 : (11'd1 << idx);
        ev   = (idx < 0) ? 8'd0 : 8'(exp_vec(idx, tn));
        evld = (idx >= 0);
        eab  = (idx >= 0) && (idx <= 2);
        checks++;
        if (exc_valid !== evld || exc_sel !== es || exc_vec !== ev || abort_now !== eab) begin
            errors++;
            $display("FAIL %s: got v=%b sel=%b vec=%0d abort=%b, expected v=%b sel=%b vec=%0d abort=%b",
                     tag, exc_valid, exc_sel, exc_vec, abort_now, evld, es, ev, eab);
        end
    endtask

    task automatic clr();
        reset_req = 0; berr_n = 1; halt_n = 1; acc_valid = 0; acc_size = 0;
        acc_fetch = 0; addr_lsb = 0; op_valid = 0; op_illegal = 0; op_priv = 0;
        sup_mode = 0; trace_en = 0; insn_done = 0; irq_pend = 0;
        trap_stb = 0; trapv_stb = 0; chk_stb = 0; div0_stb = 0; trap_num = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs stay clear in reset even with requests applied
        reset_req = 1; trap_stb = 1; div0_stb = 1;
        tick(); tick();
        chk(-1, 0, "R1 in reset");
        clr();
        rst_n = 1;
        tick();
        chk(-1, 0, "R1 after reset idle");

        // R3: address error sweep
        for (int v = 0; v < 2; v++)
            for (int s = 0; s < 3; s++)
                for (int f = 0; f < 2; f++)
                    for (int a = 0; a < 2; a++) begin
                        acc_valid = v[0]; acc_size = s[1:0]; acc_fetch = f[0]; addr_lsb = a[0];
                        tick();
                        chk((v == 1 && a == 1 && (s != 0 || f == 1)) ? 2 : -1, 0, "R3 aerr");
                        clr();
                    end

        // R4: bus error qualification
        for (int b = 0; b < 2; b++)
            for (int h = 0; h < 2; h++) begin
                berr_n = b[0]; halt_n = h[0];
                tick();
                chk((b == 0 && h == 1) ? 1 : -1, 0, "R4 berr");
                clr();
            end

        // R5 R11 R12: top rank order, drop of pending, middle beats bottom
        for (int m = 0; m < 8; m++) begin
            int e1;
            reset_req = m[0]; berr_n = ~m[1]; acc_valid = m[2]; acc_size = 2'b01; addr_lsb = 1;
            insn_done = 1; irq_pend = 1; div0_stb = 1; trap_stb = 1; trap_num = 4'd3;
            e1 = m[0] ? 0 : m[1] ? 1 : m[2] ? 2 : 4;
            tick();
            chk(e1, 3, "R5 top rank");
            clr();
            tick();
            chk(e1 < 3 ? -1 : 7, 3, e1 < 3 ? "R11 dropped" : "R12 bottom kept");
            if (e1 >= 3) begin
                tick();
                chk(10, 3, "R12 trap kept");
            end
            tick();
            chk(-1, 0, "R11 idle");
        end

        // R6 R7 R8: middle rank sweep
        for (int c = 0; c < 64; c++) begin
            bit id, tr, iq, il, pv, su, pe;
            int ea, eb;
            id = c[0]; tr = c[1]; iq = c[2]; il = c[3]; pv = c[4]; su = c[5];
            pe = pv & ~su;
            insn_done = id; trace_en = tr; irq_pend = iq; op_valid = 1;
            op_illegal = il; op_priv = pv; sup_mode = su;
            if (id) ea = tr ? 3 : iq ? 4 : il ? 5 : pe ? 6 : -1;
            else    ea = -1;
            if (id) eb = -1;
            else    eb = il ? 5 : pe ? 6 : -1;
            tick();
            chk(ea, 0, "R6 middle rank");
            clr();
            insn_done = 1;
            tick();
            chk(eb, 0, "R8 pending decode");
            clr();
            tick();
            chk(-1, 0, "R7 no leftover");
        end

        // R9: bottom rank order and drain
        for (int m = 1; m < 16; m++) begin
            int first;
            div0_stb = m[0]; chk_stb = m[1]; trapv_stb = m[2]; trap_stb = m[3];
            trap_num = 4'(m);
            first = -1;
            for (int b = 0; b < 4; b++)
                if (m[b] && first < 0) first = b;
            tick();
            chk(7 + first, m, "R9 bottom first");
            clr();
            for (int b = first + 1; b < 4; b++) begin
                if (m[b]) begin
                    tick();
                    chk(7 + b, m, "R9 bottom drain");
                end
            end
            tick();
            chk(-1, 0, "R9 drained");
        end

        // R10: software trap vectors
        for (int n = 0; n < 16; n++) begin
            trap_stb = 1; trap_num = 4'(n);
            tick();
            chk(10, n, "R10 trap vector");
            clr();
        end

        // R2: one-cycle latency of a single request
        insn_done = 1; trace_en = 1;
        tick();
        clr();
        chk(3, 0, "R2 latency");
        tick();
        chk(-1, 0, "R2 clears");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule